// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block moves one element of a DMA transfer for one channel of a four-channel controller. A request arrives with the channel number and that channel's programmed state: mode byte, current and base address, current and base count, the controller's mask and command bytes, and the channel's page byte. The block latches these values and decides whether the request is served at all. It forms the physical memory address, then either raises a memory strobe and waits for the acknowledge, or skips the access for a verify transfer. It then hands back the new address and count for the channel's registers.

At terminal count the block records completion in its status register, drops the channel's pending flag, and then does one of two things. With auto-reload enabled, the returned address and count are the base values. Without it, a one-cycle pulse asks the owner of the mask register to mask the channel. Channels can be byte-wide or word-wide, chosen per channel by a parameter. A word channel counts words and doubles the address inside a fixed 64 KiB page. The status register's completion flags clear when the CPU reads the status.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset, busy_o, mem_req_o, mem_wr_o, mem_rd_o, upd_valid_o and mask_set_o are all 0, and status_o is 0.
- R2: A request is ignored when cmd_i bit 2 (controller off) is 1, or when mask_i bit [ch_i] is 1. An ignored request produces no strobe, no update, no status change, and busy_o stays 0.
- R3: A request is also ignored, with the same effects as R2, when mode_i[7:6] is 3 (cascade) or when mode_i[3:2] is 3 (illegal transfer type).
- R4: For mode_i[3:2] = 1 (write to memory), mem_req_o and mem_wr_o rise in the cycle after the request is accepted. For mode_i[3:2] = 2 (read from memory), mem_req_o and mem_rd_o rise in that cycle instead. Exactly one of mem_wr_o and mem_rd_o is high while mem_req_o is high. mem_req_o and mem_addr_o hold until a cycle with mem_ack_i high, and mem_req_o drops after that cycle.
- R5: For mode_i[3:2] = 0 (verify), no strobe is raised, and the update appears two cycles after the request is accepted.
- R6: In the cycle after the acknowledge, upd_valid_o is high for exactly one cycle. In that cycle upd_ch_o is the channel and upd_cnt_o is the count minus one. upd_addr_o is the address plus one, or minus one when mode_i bit 5 is 1 (modulo 2^16).
- R7: On a byte channel (WIDE_MASK bit 0), mem_addr_o is {page_i, cur_addr_i}.
- R8: On a word channel (WIDE_MASK bit 1), mem_addr_o is {page_i, cur_addr_i[14:0], 0}.
- R9: An accepted request sets status bit [4+ch]. When the decremented count is 0 (terminal count), status bit [ch] is set and bit [4+ch] is cleared, in the same cycle as upd_valid_o.
- R10: At terminal count with mode_i bit 4 (auto-reload) set, upd_addr_o and upd_cnt_o carry base_addr_i and base_cnt_i, and mask_set_o stays 0.
- R11: At terminal count without auto-reload, mask_set_o is one-hot at bit [ch] for the single cycle of upd_valid_o. Otherwise mask_set_o is 0.
- R12: A status_rd_i pulse clears status bits [3:0] and leaves bits [7:4] unchanged. When a terminal count falls in the same cycle, that channel's completion bit is set regardless.
- R13: mode_i[7:6] = 0 (demand) and 2 (block) move one element per request, exactly like 1 (single).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request one element; accepted only while idle |
| ch_i | input | 2 | Channel number |
| mode_i | input | 8 | Channel mode byte |
| cur_addr_i | input | 16 | Channel current address |
| cur_cnt_i | input | 16 | Channel current count |
| base_addr_i | input | 16 | Channel base address |
| base_cnt_i | input | 16 | Channel base count |
| mask_i | input | 4 | Controller channel mask |
| cmd_i | input | 8 | Controller command byte |
| page_i | input | 8 | Channel page byte |
| mem_ack_i | input | 1 | Memory acknowledge |
| status_rd_i | input | 1 | CPU read of status register |
| busy_o | output | 1 | An element is in flight |
| mem_req_o | output | 1 | Memory strobe request |
| mem_wr_o | output | 1 | Strobe is a memory write |
| mem_rd_o | output | 1 | Strobe is a memory read |
| mem_addr_o | output | 24 | Physical memory address |
| upd_valid_o | output | 1 | New address and count are valid |
| upd_ch_o | output | 2 | Channel being updated |
| upd_addr_o | output | 16 | New current address |
| upd_cnt_o | output | 16 | New current count |
| mask_set_o | output | 4 | One-hot request to set a mask bit |
| status_o | output | 8 | Status: completion flags low, pending flags high |

## Verification
Every output is registered, so its timing can be counted from the accepting edge. The strobe is due one cycle after that edge. The update, the mask pulse and the terminal-count status change are due one cycle after the acknowledge edge, or two cycles after acceptance for a verify. The bench drives and samples on falling edges. It checks each result on the one falling edge where it is due, and checks that the strobe stays high through each cycle it waits for the acknowledge. For ignored requests it checks over the same window that nothing happened. A status read is issued both on its own and in the same cycle as a terminal count, and the status is compared with a model after each.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    OP_DEMAND  = 2'd0,
    OP_SINGLE  = 2'd1,
    OP_BLOCK   = 2'd2,
    OP_CASCADE = 2'd3
  } op_mode_e;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'd0,
    XT_MEMWR   = 2'd1,
    XT_MEMRD   = 2'd2,
    XT_ILLEGAL = 2'd3
  } xfer_type_e;

  typedef struct packed {
    op_mode_e   op;
    logic       down;
    logic       reload;
    xfer_type_e xt;
  } mode_fields_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_VER  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_seq_pkg::*;
(
  input  logic [7:0]   mode_i,
  input  logic         ctrl_off_i,
  input  logic         ch_masked_i,
  output mode_fields_t fields_o,
  output logic         ignore_o,
  output logic         access_o
);
  always_comb begin
    fields_o.op     = op_mode_e'(mode_i[7:6]);
    fields_o.down   = mode_i[5];
    fields_o.reload = mode_i[4];
    fields_o.xt     = xfer_type_e'(mode_i[3:2]);
    ignore_o = ctrl_off_i || ch_masked_i ||
               (fields_o.op == OP_CASCADE) || (fields_o.xt == XT_ILLEGAL);
    access_o = (fields_o.xt == XT_MEMWR) || (fields_o.xt == XT_MEMRD);
  end
endmodule

// File: rtl/dma_phys_addr.sv
module dma_phys_addr #(
  parameter int AW   = 16,
  parameter int PW   = 8,
  parameter bit WIDE = 1'b0
) (
  input  logic [PW-1:0]    page_i,
  input  logic [AW-1:0]    addr_i,
  output logic [PW+AW-1:0] phys_o
);
  generate
    if (WIDE) begin : g_word
      assign phys_o = {page_i, addr_i[AW-2:0], 1'b0};
    end else begin : g_byte
      assign phys_o = {page_i, addr_i};
    end
  endgenerate
endmodule

// File: rtl/dma_status_reg.sv
module dma_status_reg #(
  parameter int NUM_CH = 4,
  localparam int CHW = $clog2(NUM_CH),
  localparam int SW  = 2 * NUM_CH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pend_set_i,
  input  logic [CHW-1:0] pend_ch_i,
  input  logic           tc_i,
  input  logic [CHW-1:0] tc_ch_i,
  input  logic           rd_clr_i,
  output logic [SW-1:0]  status_o
);
  logic [SW-1:0] nxt;

  always_comb begin
    nxt = status_o;
    if (rd_clr_i) nxt[NUM_CH-1:0] = '0;
    if (pend_set_i) nxt[NUM_CH + int'(pend_ch_i)] = 1'b1;
    if (tc_i) begin
      nxt[int'(tc_ch_i)]          = 1'b1;
      nxt[NUM_CH + int'(tc_ch_i)] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_o <= '0;
    else     status_o <= nxt;
  end

  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i && !tc_i |=> status_o[NUM_CH-1:0] == '0); // R12
  AST_TC_FLAG: assert property (@(posedge clk) disable iff (rst)
    tc_i |=> status_o[$past(tc_ch_i)] && !status_o[NUM_CH + int'($past(tc_ch_i))]); // R9
  AST_RD_KEEPS_PEND: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i && !tc_i && !pend_set_i |=> $stable(status_o[SW-1:NUM_CH])); // R12
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_seq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int AW     = 16,
  parameter int CW     = 16,
  parameter int PW     = 8,
  parameter logic [NUM_CH-1:0] WIDE_MASK = 4'b1100,
  localparam int CHW = $clog2(NUM_CH),
  localparam int SW  = 2 * NUM_CH,
  localparam int MW  = PW + AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [CHW-1:0]    ch_i,
  input  logic [7:0]        mode_i,
  input  logic [AW-1:0]     cur_addr_i,
  input  logic [CW-1:0]     cur_cnt_i,
  input  logic [AW-1:0]     base_addr_i,
  input  logic [CW-1:0]     base_cnt_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic [7:0]        cmd_i,
  input  logic [PW-1:0]     page_i,
  input  logic              mem_ack_i,
  input  logic              status_rd_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_wr_o,
  output logic              mem_rd_o,
  output logic [MW-1:0]     mem_addr_o,
  output logic              upd_valid_o,
  output logic [CHW-1:0]    upd_ch_o,
  output logic [AW-1:0]     upd_addr_o,
  output logic [CW-1:0]     upd_cnt_o,
  output logic [NUM_CH-1:0] mask_set_o,
  output logic [SW-1:0]     status_o
);
  seq_state_e   state;
  mode_fields_t dec_fields, fields_q;
  logic         ignore, access;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  addr_q, baddr_q, nxt_addr;
  logic [CW-1:0]  cnt_q, bcnt_q, nxt_cnt;
  logic [MW-1:0]  phys_all [NUM_CH];
  logic accept, finish, tc;

  dma_mode_decode u_dec (
    .mode_i      (mode_i),
    .ctrl_off_i  (cmd_i[2]),
    .ch_masked_i (mask_i[ch_i]),
    .fields_o    (dec_fields),
    .ignore_o    (ignore),
    .access_o    (access)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_ch
      dma_phys_addr #(.AW(AW), .PW(PW), .WIDE(WIDE_MASK[gi])) u_pa (
        .page_i (page_i),
        .addr_i (cur_addr_i),
        .phys_o (phys_all[gi])
      );
    end
  endgenerate

  assign accept = (state == S_IDLE) && req_i && !ignore;
  assign finish = ((state == S_WAIT) && mem_ack_i) || (state == S_VER);
  assign busy_o = (state != S_IDLE);

  always_comb begin
    nxt_cnt = cnt_q - 1'b1;
    tc      = (nxt_cnt == '0);
    nxt_addr = fields_q.down ? (addr_q - 1'b1) : (addr_q + 1'b1);
    if (tc && fields_q.reload) begin
      nxt_addr = baddr_q;
      nxt_cnt  = bcnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      mem_req_o   <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_rd_o    <= 1'b0;
      mem_addr_o  <= '0;
      upd_valid_o <= 1'b0;
      upd_ch_o    <= '0;
      upd_addr_o  <= '0;
      upd_cnt_o   <= '0;
      mask_set_o  <= '0;
      ch_q        <= '0;
      fields_q    <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      baddr_q     <= '0;
      bcnt_q      <= '0;
    end else begin
      upd_valid_o <= 1'b0;
      mask_set_o  <= '0;
      case (state)
        S_IDLE: if (accept) begin
          ch_q       <= ch_i;
          fields_q   <= dec_fields;
          addr_q     <= cur_addr_i;
          cnt_q      <= cur_cnt_i;
          baddr_q    <= base_addr_i;
          bcnt_q     <= base_cnt_i;
          mem_addr_o <= phys_all[ch_i];
          if (access) begin
            mem_req_o <= 1'b1;
            mem_wr_o  <= (dec_fields.xt == XT_MEMWR);
            mem_rd_o  <= (dec_fields.xt == XT_MEMRD);
            state     <= S_WAIT;
          end else begin
            state <= S_VER;
          end
        end
        S_WAIT: if (mem_ack_i) begin
          mem_req_o <= 1'b0;
          mem_wr_o  <= 1'b0;
          mem_rd_o  <= 1'b0;
          state     <= S_IDLE;
        end
        S_VER: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
      if (finish) begin
        upd_valid_o <= 1'b1;
        upd_ch_o    <= ch_q;
        upd_addr_o  <= nxt_addr;
        upd_cnt_o   <= nxt_cnt;
        if (tc && !fields_q.reload) mask_set_o <= NUM_CH'(1) << ch_q;
      end
    end
  end

  dma_status_reg #(.NUM_CH(NUM_CH)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .pend_set_i (accept),
    .pend_ch_i  (ch_i),
    .tc_i       (finish && tc),
    .tc_ch_i    (ch_q),
    .rd_clr_i   (status_rd_i),
    .status_o   (status_o)
  );

  AST_STROBE_DIR: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |-> (mem_wr_o ^ mem_rd_o)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R4
  AST_UPD_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    mem_req_o && mem_ack_i |=> upd_valid_o && !mem_req_o); // R6
  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    upd_valid_o |=> !upd_valid_o); // R6
  AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) && req_i && ignore |=> !mem_req_o && !busy_o); // R2
  AST_MASK_AT_TC: assert property (@(posedge clk) disable iff (rst)
    (mask_set_o != '0) |-> upd_valid_o && (upd_cnt_o == '0) && $onehot(mask_set_o)); // R11
endmodule

// File: tb/dma_xfer_seq_test.sv
module dma_xfer_seq_test;
  localparam logic [3:0] WIDE = 4'b1100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_i = 1'b0;
  logic [1:0] ch_i = '0;
  logic [7:0] mode_i = '0;
  logic [15:0] cur_addr_i = '0, cur_cnt_i = '0, base_addr_i = '0, base_cnt_i = '0;
  logic [3:0] mask_i = '0;
  logic [7:0] cmd_i = '0, page_i = '0;
  logic mem_ack_i = 1'b0, status_rd_i = 1'b0;
  logic busy_o, mem_req_o, mem_wr_o, mem_rd_o, upd_valid_o;
  logic [23:0] mem_addr_o;
  logic [1:0] upd_ch_o;
  logic [15:0] upd_addr_o, upd_cnt_o;
  logic [3:0] mask_set_o;
  logic [7:0] status_o;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_status = '0;

  always #4 clk = ~clk;

  dma_xfer_seq #(.WIDE_MASK(WIDE)) uut (
    .clk(clk), .rst(rst), .req_i(req_i), .ch_i(ch_i), .mode_i(mode_i),
    .cur_addr_i(cur_addr_i), .cur_cnt_i(cur_cnt_i), .base_addr_i(base_addr_i),
    .base_cnt_i(base_cnt_i), .mask_i(mask_i), .cmd_i(cmd_i), .page_i(page_i),
    .mem_ack_i(mem_ack_i), .status_rd_i(status_rd_i), .busy_o(busy_o),
    .mem_req_o(mem_req_o), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o),
    .mem_addr_o(mem_addr_o), .upd_valid_o(upd_valid_o), .upd_ch_o(upd_ch_o),
    .upd_addr_o(upd_addr_o), .upd_cnt_o(upd_cnt_o), .mask_set_o(mask_set_o),
    .status_o(status_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_phys(input logic [1:0] ch,
                                            input logic [7:0] pg, input logic [15:0] a);
    return WIDE[ch] ? {pg, a[14:0], 1'b0} : {pg, a};
  endfunction

  function automatic bit exp_ignore(input logic [7:0] md, input logic [3:0] mk,
                                    input logic [7:0] cm, input logic [1:0] ch);
    return cm[2] || mk[ch] || (md[7:6] == 2'd3) || (md[3:2] == 2'd3);
  endfunction

  task automatic status_read();
    status_rd_i = 1'b1;
    @(negedge clk);
    status_rd_i = 1'b0;
    exp_status[3:0] = 4'h0;
    chk("R12", "status after read", 32'(status_o), 32'(exp_status));
  endtask

  task automatic run_elem(input logic [1:0] ch, input logic [7:0] md,
                          input logic [15:0] a, input logic [15:0] c,
                          input logic [15:0] ba, input logic [15:0] bc,
                          input logic [3:0] mk, input logic [7:0] cm,
                          input logic [7:0] pg, input int ack_dly, input bit rd_at_fin);
    logic [15:0] ecnt, eaddr;
    logic [3:0]  emask;
    bit tc;
    ch_i = ch; mode_i = md; cur_addr_i = a; cur_cnt_i = c; base_addr_i = ba;
    base_cnt_i = bc; mask_i = mk; cmd_i = cm; page_i = pg; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    if (exp_ignore(md, mk, cm, ch)) begin
      string t = (cm[2] || mk[ch]) ? "R2" : "R3";
      chk(t, "busy on ignored", 32'(busy_o), 0);
      chk(t, "mem_req on ignored", 32'(mem_req_o), 0);
      @(negedge clk);
      chk(t, "upd_valid on ignored", 32'(upd_valid_o), 0);
      chk(t, "status on ignored", 32'(status_o), 32'(exp_status));
      return;
    end
    exp_status[4 + ch] = 1'b1;
    if (md[3:2] == 2'd0) begin
      chk("R5", "mem_req on verify", 32'(mem_req_o), 0);
      chk("R5", "busy on verify", 32'(busy_o), 1);
      if (rd_at_fin) status_rd_i = 1'b1;
      @(negedge clk);
      status_rd_i = 1'b0;
      if (rd_at_fin) exp_status[3:0] = 4'h0;
      chk("R5", "upd_valid after verify", 32'(upd_valid_o), 1);
    end else begin
      chk("R4", "mem_req raised", 32'(mem_req_o), 1);
      chk("R4", "mem_wr", 32'(mem_wr_o), 32'(md[3:2] == 2'd1));
      chk("R4", "mem_rd", 32'(mem_rd_o), 32'(md[3:2] == 2'd2));
      chk(WIDE[ch] ? "R8" : "R7", "mem_addr", 32'(mem_addr_o), 32'(exp_phys(ch, pg, a)));
      for (int i = 0; i < ack_dly; i++) begin
        @(negedge clk);
        chk("R4", "mem_req held", 32'(mem_req_o), 1);
        chk("R6", "no early upd", 32'(upd_valid_o), 0);
      end
      mem_ack_i = 1'b1;
      @(negedge clk);
      mem_ack_i = 1'b0;
      chk("R4", "mem_req dropped", 32'(mem_req_o), 0);
      chk("R6", "upd_valid after ack", 32'(upd_valid_o), 1);
    end
    ecnt  = c - 16'd1;
    tc    = (ecnt == 16'd0);
    eaddr = md[5] ? a - 16'd1 : a + 16'd1;
    emask = 4'h0;
    if (tc) begin
      exp_status[ch] = 1'b1;
      exp_status[4 + ch] = 1'b0;
      if (md[4]) begin eaddr = ba; ecnt = bc; end
      else emask = 4'h1 << ch;
    end
    chk("R6", "upd_ch", 32'(upd_ch_o), 32'(ch));
    chk((tc && md[4]) ? "R10" : "R6", "upd_addr", 32'(upd_addr_o), 32'(eaddr));
    chk((tc && md[4]) ? "R10" : "R6", "upd_cnt", 32'(upd_cnt_o), 32'(ecnt));
    chk("R11", "mask_set", 32'(mask_set_o), 32'(emask));
    chk(rd_at_fin ? "R12" : "R9", "status", 32'(status_o), 32'(exp_status));
    if (md[7:6] != 2'd1) chk("R13", "busy done", 32'(busy_o), 0);
    @(negedge clk);
    chk("R6", "upd one cycle", 32'(upd_valid_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy", 32'(busy_o), 0);
    chk("R1", "mem_req", 32'(mem_req_o), 0);
    chk("R1", "mem_wr/rd", 32'({mem_wr_o, mem_rd_o}), 0);
    chk("R1", "upd_valid", 32'(upd_valid_o), 0);
    chk("R1", "mask_set", 32'(mask_set_o), 0);
    chk("R1", "status", 32'(status_o), 0);

    // Directed corners: byte write up, word read down, verify, TC variants
    run_elem(2'd1, 8'b01_0_0_01_00, 16'h1234, 16'd5, 16'h0, 16'h0, 4'h0, 8'h00, 8'h3A, 1, 0);
    run_elem(2'd2, 8'b01_1_0_10_00, 16'hC001, 16'd9, 16'h0, 16'h0, 4'h0, 8'h07, 8'h12, 0, 0);
    run_elem(2'd0, 8'b01_0_0_00_00, 16'hFFFF, 16'd3, 16'h0, 16'h0, 4'h0, 8'h00, 8'h01, 0, 0);
    run_elem(2'd3, 8'b01_0_1_01_00, 16'h0100, 16'd1, 16'hBEEF, 16'h0040, 4'h0, 8'h00, 8'h55, 2, 0);
    run_elem(2'd1, 8'b01_0_0_10_00, 16'h0000, 16'd1, 16'h0, 16'h0, 4'h0, 8'h00, 8'h00, 0, 0);
    run_elem(2'd2, 8'b01_1_0_01_00, 16'h0000, 16'd2, 16'h0, 16'h0, 4'h0, 8'h04, 8'h00, 0, 0);
    run_elem(2'd2, 8'b01_1_0_01_00, 16'h0000, 16'd2, 16'h0, 16'h0, 4'h4, 8'h00, 8'h00, 0, 0);
    run_elem(2'd0, 8'b11_0_0_01_00, 16'h0000, 16'd2, 16'h0, 16'h0, 4'h0, 8'h00, 8'h00, 0, 0);
    run_elem(2'd0, 8'b01_0_0_11_00, 16'h0000, 16'd2, 16'h0, 16'h0, 4'h0, 8'h00, 8'h00, 0, 0);
    run_elem(2'd3, 8'b00_0_0_10_00, 16'h7777, 16'd4, 16'h0, 16'h0, 4'h0, 8'h00, 8'h9C, 1, 0);
    run_elem(2'd0, 8'b10_1_0_01_00, 16'h2000, 16'd4, 16'h0, 16'h0, 4'h0, 8'h00, 8'h9C, 0, 0);
    status_read();
    run_elem(2'd2, 8'b01_0_0_00_00, 16'h0010, 16'd1, 16'h0, 16'h0, 4'h0, 8'h00, 8'h00, 0, 1);
    status_read();

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [1:0] ch;
      logic [7:0] md;
      logic [15:0] c;
      logic [3:0] mk;
      ch = 2'($urandom % 4);
      md = 8'($urandom);
      if ($urandom % 4 != 0) md[7:6] = 2'd1;
      if ($urandom % 5 != 0 && md[3:2] == 2'd3) md[3:2] = 2'd1;
      c  = ($urandom % 3 == 0) ? 16'd1 : 16'($urandom % 8);
      mk = ($urandom % 8 == 0) ? (4'h1 << ch) : 4'($urandom) & ~(4'h1 << ch);
      run_elem(ch, md, 16'($urandom), c, 16'($urandom), 16'($urandom), mk,
               ($urandom % 10 == 0) ? 8'h04 : 8'h00, 8'($urandom),
               int'($urandom % 3), ($urandom % 6 == 0));
      if ($urandom % 7 == 0) status_read();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule